// File: doc/BRIEF.md
# Configurable Logic Macrocell Register

This block is a single programmable logic cell. Five product-term inputs are masked into an OR sum, which can be extended by a cascade input from the previous cell in a chain; the resulting sum leaves the cell again as a cascade output. The sum passes through an XOR stage whose second input is a product term or a constant, so the cell can invert its function or fold in one more term. The XOR result, a dedicated product term or the pin input feeds a storage element. That element is set up as a D, T, JK or SR flip-flop, or as a level-sensitive latch.

The cell runs on one system clock `clk`. The three global clocks and a product-term clock are sampled on that clock, and the element advances on each sampled low-to-high transition of the chosen source. Asynchronous clear and set act on the outputs at once, without waiting for a `clk` edge, and they take over the stored value at the next `clk` edge. A 21-bit configuration word is captured only while `cfg_load` is high. It selects every source and mode, and it chooses independently whether the pin output and the feedback output are taken from the storage element or from the XOR result.

Configuration word layout (bit 20 down to 0): `[20:16]` sum mask, one bit per product term; `[15]` cascade-in enable; `[14:13]` XOR select; `[12:11]` data source; `[10:8]` storage mode; `[7:6]` clock source; `[5]` clock-enable use; `[4:3]` clear source; `[2]` set enable; `[1]` pin output registered; `[0]` feedback registered. Product-term roles with the default parameters: term 4 is the XOR operand, term 3 is direct data and J/S, term 2 is K/R, term 1 is the product clock and the clear term, and term 0 is the clock enable and the set term.

Top module: `mc_cell`

## Requirements
- R1: After `rst_n` has been low, the configuration is all zero and the stored value is 0. With that configuration `pin_out`, `fb_out` and `casc_out` are 0.
- R2: The configuration word is captured at a `clk` edge only while `cfg_load` is 1. Otherwise changes on `cfg_word` have no effect on the outputs.
- R3: `casc_out` is the OR of `pt[i]` for every i whose mask bit is set, ORed with `casc_in` when the cascade-in enable bit is 1. Product terms with a clear mask bit do not contribute.
- R4: The XOR result is the sum XOR a second operand. The XOR select field picks this operand: 0 gives constant 0, 1 gives constant 1, and 2 or 3 give `pt[4]`.
- R5: The data source field picks the storage input: 0 gives the XOR result, 1 gives `pt[3]`, and 2 or 3 give `pin_in`.
- R6: In mode 0 (D) a clock event loads the data input. In mode 1 (T) a clock event inverts the stored value when the data input is 1.
- R7: In mode 2 (JK, J = data input, K = `pt[2]`) a clock event holds, clears, sets or toggles for JK = 00, 01, 10, 11. In mode 3 (SR, S = data input, R = `pt[2]`) it holds for 00, clears for 01, sets for 10, and clears for 11.
- R8: In mode 4 (latch) the registered output follows the data input in the same cycle while the selected clock is high. It keeps the last value while the clock is low.
- R9: The clock source field picks `gclk[0]`, `gclk[1]`, `gclk[2]` (values 0 to 2) or `pt[1]` (value 3). Only a low-to-high transition of the selected source is a clock event, and a source held high gives one event.
- R10: When the clock-enable bit is 1 and a global clock is selected, clock events with `pt[0]` low are ignored. With the product-term clock, `pt[0]` has no gating effect.
- R11: The clear source field picks off (0), `gclr` (1), `pt[1]` (2) or either of them (3). An active clear forces the registered output to 0 at once and clears the stored value. Clear wins over set.
- R12: When the set enable bit is 1, `pt[0]` high forces the registered output to 1 at once and sets the stored value.
- R13: `pin_out` is the registered value when bit 1 is set, and the XOR result otherwise. `fb_out` makes the same choice from bit 0, independently of `pin_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all sampling happens on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset (power-up clear) |
| cfg_load | input | 1 | Configuration capture strobe |
| cfg_word | input | 21 | Configuration word, layout above |
| pt | input | 5 | Product-term inputs |
| casc_in | input | 1 | Sum from the previous cell of the chain |
| gclk | input | 3 | Global clock sources |
| gclr | input | 1 | Global clear |
| pin_in | input | 1 | Pin input, usable as direct storage data |
| pin_out | output | 1 | Pin output, registered or combinational |
| fb_out | output | 1 | Feedback output, registered or combinational |
| casc_out | output | 1 | Sum passed to the next cell of the chain |

## Verification
The sum path is driven with masked-out terms that must stay silent, with a single enabled term, and with the cascade input alone. Together these separate the mask from the cascade enable. The XOR stage runs with a product-term operand in both states and with each constant, so inversion is told apart from pass-through. The storage element goes through every JK and SR input pair from known start values, through T toggles, and through a global clock held high for several cycles, which separates edge detection from level sensing. The latch is checked both during transparency and after the clock falls. The clear and set tests check the output before any `clk` edge and after it, and each clear source is also shown to be ignored when it is not selected.

// File: rtl/mc_pkg.sv
package mc_pkg;

   typedef enum logic [1:0] {
      XS_ZERO   = 2'd0,
      XS_ONE    = 2'd1,
      XS_PT     = 2'd2,
      XS_PT_ALT = 2'd3
   } xor_sel_e;

   typedef enum logic [1:0] {
      DS_XOR     = 2'd0,
      DS_PT      = 2'd1,
      DS_PIN     = 2'd2,
      DS_PIN_ALT = 2'd3
   } dsrc_e;

   typedef enum logic [2:0] {
      FF_D   = 3'd0,
      FF_T   = 3'd1,
      FF_JK  = 3'd2,
      FF_SR  = 3'd3,
      FF_LAT = 3'd4,
      FF_R5  = 3'd5,
      FF_R6  = 3'd6,
      FF_R7  = 3'd7
   } ffmode_e;

   typedef enum logic [1:0] {
      CK_G0 = 2'd0,
      CK_G1 = 2'd1,
      CK_G2 = 2'd2,
      CK_PT = 2'd3
   } clksrc_e;

   typedef enum logic [1:0] {
      AR_OFF  = 2'd0,
      AR_GCLR = 2'd1,
      AR_PT   = 2'd2,
      AR_BOTH = 2'd3
   } arsrc_e;

   typedef struct packed {
      logic     casc_en;
      xor_sel_e xsel;
      dsrc_e    dsrc;
      ffmode_e  mode;
      clksrc_e  cksrc;
      logic     ce_en;
      arsrc_e   arsrc;
      logic     ap_en;
      logic     out_reg;
      logic     fb_reg;
   } mc_ctrl_t;

   localparam int CTRL_W = $bits(mc_ctrl_t);

endpackage

// File: rtl/mc_sum_xor.sv
module mc_sum_xor #(
   parameter int NPT = 5
) (
   input  logic                 [NPT-1:0] pt,
   input  logic                 [NPT-1:0] mask,
   input  logic                           casc_in,
   input  logic                           casc_en,
   input  logic                           xor_pt,
   input  mc_pkg::xor_sel_e               xsel,
   output logic                           sum,
   output logic                           xo
);
   import mc_pkg::*;

   logic [NPT-1:0] term;
   logic           operand;

   for (genvar i = 0; i < NPT; i++) begin : g_term
      assign term[i] = mask[i] & pt[i];
   end

   assign sum = (|term) | (casc_en & casc_in);

   always_comb begin
      unique case (xsel)
         XS_ZERO: operand = 1'b0;
         XS_ONE:  operand = 1'b1;
         default: operand = xor_pt;
      endcase
   end

   assign xo = sum ^ operand;

endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl #(
   parameter int NGCK = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NGCK-1:0]     gclk,
   input  logic                clk_pt,
   input  logic                ce_pt,
   input  logic                ar_pt,
   input  logic                ap_pt,
   input  logic                gclr,
   input  mc_pkg::clksrc_e     cksrc,
   input  logic                ce_en,
   input  mc_pkg::arsrc_e      arsrc,
   input  logic                ap_en,
   output logic                lvl,
   output logic                tick,
   output logic                ar_act,
   output logic                ap_act
);
   import mc_pkg::*;

   localparam int NSRC = NGCK + 1;
   localparam int SW   = $clog2(NSRC);

   logic [NSRC-1:0] src_lvl;
   logic [NSRC-1:0] prev_q;
   logic [SW-1:0]   sel;
   logic            rise;
   logic            use_gck;
   logic            ce_ok;

   assign src_lvl = {clk_pt, gclk};
   assign sel     = SW'(cksrc);
   assign lvl     = src_lvl[sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= src_lvl;
   end

   assign rise    = lvl & ~prev_q[sel];
   assign use_gck = (cksrc != CK_PT);
   assign ce_ok   = ~ce_en | ~use_gck | ce_pt;
   assign tick    = rise & ce_ok;

   always_comb begin
      unique case (arsrc)
         AR_OFF:  ar_act = 1'b0;
         AR_GCLR: ar_act = gclr;
         AR_PT:   ar_act = ar_pt;
         default: ar_act = gclr | ar_pt;
      endcase
   end

   assign ap_act = ap_en & ap_pt;

endmodule

// File: rtl/mc_store.sv
module mc_store #(
   parameter bit SUPPORT_LATCH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  mc_pkg::ffmode_e   mode,
   input  logic              d,
   input  logic              aux,
   input  logic              tick,
   input  logic              lvl,
   input  logic              ar_act,
   input  logic              ap_act,
   output logic              st_q,
   output logic              q
);
   import mc_pkg::*;

   logic is_lat;
   logic nxt;

   if (SUPPORT_LATCH) begin : g_lat
      assign is_lat = (mode == FF_LAT);
   end else begin : g_nolat
      assign is_lat = 1'b0;
   end

   always_comb begin
      unique case (mode)
         FF_T: nxt = st_q ^ d;
         FF_JK: begin
            unique case ({d, aux})
               2'b00:   nxt = st_q;
               2'b01:   nxt = 1'b0;
               2'b10:   nxt = 1'b1;
               default: nxt = ~st_q;
            endcase
         end
         FF_SR: begin
            unique case ({d, aux})
               2'b00:   nxt = st_q;
               2'b10:   nxt = 1'b1;
               default: nxt = 1'b0;
            endcase
         end
         default: nxt = d;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             st_q <= 1'b0;
      else if (ar_act)        st_q <= 1'b0;
      else if (ap_act)        st_q <= 1'b1;
      else if (is_lat)        st_q <= lvl ? d : st_q;
      else if (tick)          st_q <= nxt;
   end

   always_comb begin
      if (ar_act)              q = 1'b0;
      else if (ap_act)         q = 1'b1;
      else if (is_lat && lvl)  q = d;
      else                     q = st_q;
   end

endmodule

// File: rtl/mc_cell.sv
module mc_cell #(
   parameter int NPT           = 5,
   parameter int NGCK          = 3,
   parameter int XOR_PT        = 4,
   parameter int D_PT          = 3,
   parameter int AUX_PT        = 2,
   parameter int CLK_PT        = 1,
   parameter int AR_PT         = 1,
   parameter int CE_PT         = 0,
   parameter int AP_PT         = 0,
   parameter bit SUPPORT_LATCH = 1'b1,
   localparam int CFG_W        = NPT + mc_pkg::CTRL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_load,
   input  logic [CFG_W-1:0]  cfg_word,
   input  logic [NPT-1:0]    pt,
   input  logic              casc_in,
   input  logic [NGCK-1:0]   gclk,
   input  logic              gclr,
   input  logic              pin_in,
   output logic              pin_out,
   output logic              fb_out,
   output logic              casc_out
);
   import mc_pkg::*;

   if (NPT < 1) begin : g_bad_npt
      $error("mc_cell: NPT must be at least 1");
   end
   if (NGCK != 3) begin : g_bad_ngck
      $error("mc_cell: clock select field encodes exactly three global clocks");
   end
   if (XOR_PT >= NPT || D_PT >= NPT || AUX_PT >= NPT || CLK_PT >= NPT ||
       AR_PT >= NPT || CE_PT >= NPT || AP_PT >= NPT) begin : g_bad_idx
      $error("mc_cell: product term role index out of range");
   end

   logic [CFG_W-1:0] cfg_q;
   mc_ctrl_t         ctl;
   logic [NPT-1:0]   mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cfg_q <= '0;
      else if (cfg_load) cfg_q <= cfg_word;
   end

   assign ctl  = mc_ctrl_t'(cfg_q[CTRL_W-1:0]);
   assign mask = cfg_q[CFG_W-1:CTRL_W];

   logic sum, xo;

   mc_sum_xor #(.NPT(NPT)) u_sum (
      .pt      (pt),
      .mask    (mask),
      .casc_in (casc_in),
      .casc_en (ctl.casc_en),
      .xor_pt  (pt[XOR_PT]),
      .xsel    (ctl.xsel),
      .sum     (sum),
      .xo      (xo)
   );

   assign casc_out = sum;

   logic lvl, tick, ar_act, ap_act;

   mc_ctrl #(.NGCK(NGCK)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .gclk   (gclk),
      .clk_pt (pt[CLK_PT]),
      .ce_pt  (pt[CE_PT]),
      .ar_pt  (pt[AR_PT]),
      .ap_pt  (pt[AP_PT]),
      .gclr   (gclr),
      .cksrc  (ctl.cksrc),
      .ce_en  (ctl.ce_en),
      .arsrc  (ctl.arsrc),
      .ap_en  (ctl.ap_en),
      .lvl    (lvl),
      .tick   (tick),
      .ar_act (ar_act),
      .ap_act (ap_act)
   );

   logic din;

   always_comb begin
      unique case (ctl.dsrc)
         DS_XOR:  din = xo;
         DS_PT:   din = pt[D_PT];
         default: din = pin_in;
      endcase
   end

   logic st_q, q;

   mc_store #(.SUPPORT_LATCH(SUPPORT_LATCH)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode   (ctl.mode),
      .d      (din),
      .aux    (pt[AUX_PT]),
      .tick   (tick),
      .lvl    (lvl),
      .ar_act (ar_act),
      .ap_act (ap_act),
      .st_q   (st_q),
      .q      (q)
   );

   assign pin_out = ctl.out_reg ? q : xo;
   assign fb_out  = ctl.fb_reg  ? q : xo;

endmodule

// File: rtl/mc_cell_chk.sv
module mc_cell_chk #(
   parameter int CFG_W = 21
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_load,
   input logic [CFG_W-1:0] cfg_q,
   input logic             casc_in,
   input logic             casc_out,
   input logic             pin_out,
   input logic             fb_out,
   input logic             st_q,
   input logic             tick,
   input logic             ar_act,
   input logic             ap_act
);

   // R2
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_load |=> $stable(cfg_q));

   // R11
   clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ar_act |=> !st_q);

   // R12
   preset_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ap_act && !ar_act) |=> st_q);

   // R6
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !ar_act && !ap_act && cfg_q[10:8] != 3'd4) |=> $stable(st_q));

   // R3
   casc_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[15] && casc_in) |-> casc_out);

   // R13
   same_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[1] == cfg_q[0]) |-> (pin_out == fb_out));

endmodule

bind mc_cell mc_cell_chk #(.CFG_W(CFG_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_load (cfg_load),
   .cfg_q    (cfg_q),
   .casc_in  (casc_in),
   .casc_out (casc_out),
   .pin_out  (pin_out),
   .fb_out   (fb_out),
   .st_q     (st_q),
   .tick     (tick),
   .ar_act   (ar_act),
   .ap_act   (ap_act)
);

// File: tb/tb_mc_cell.sv
`timescale 1ns/1ps
module tb_mc_cell;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_load = 1'b0;
   logic [20:0] cfg_word = '0;
   logic [4:0]  pt = '0;
   logic        casc_in = 1'b0;
   logic [2:0]  gclk = '0;
   logic        gclr = 1'b0;
   logic        pin_in = 1'b0;
   logic        pin_out, fb_out, casc_out;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   mc_cell dut (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_word(cfg_word),
      .pt(pt), .casc_in(casc_in), .gclk(gclk), .gclr(gclr), .pin_in(pin_in),
      .pin_out(pin_out), .fb_out(fb_out), .casc_out(casc_out)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [20:0] cw(input logic [4:0] m, input logic cen,
         input logic [1:0] xs, input logic [1:0] ds, input logic [2:0] ff,
         input logic [1:0] cs, input logic ce, input logic [1:0] ar,
         input logic ap, input logic orr, input logic fbr);
      return {m, cen, xs, ds, ff, cs, ce, ar, ap, orr, fbr};
   endfunction

   task automatic load(input logic [20:0] w);
      @(negedge clk);
      cfg_word = w;
      cfg_load = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
      #1;
   endtask

   task automatic pulse(input int src);
      @(negedge clk);
      if (src == 3) pt[1] = 1'b1; else gclk[src] = 1'b1;
      @(negedge clk);
      if (src == 3) pt[1] = 1'b0; else gclk[src] = 1'b0;
      #1;
   endtask

   task automatic set_state(input logic v);
      load(cw(5'b0, 1'b0, 2'd0, 2'd2, 3'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1));
      pin_in = v;
      pulse(0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 pin_out after reset", pin_out, 1'b0);
      chk("R1 fb_out after reset", fb_out, 1'b0);
      chk("R1 casc_out after reset", casc_out, 1'b0);
      set_state(1'b1);
      chk("R1 preload stored 1", pin_out, 1'b1);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      #1;
      chk("R1 config cleared", pin_out, 1'b0);
      load(cw(5'b0, 1'b0, 2'd1, 2'd0, 3'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0));
      chk("R1 stored value cleared", pin_out, 1'b0);
      chk("R1 comb fb after reset", fb_out, 1'b1);
   endtask

   task automatic t_cfg_hold();
      load(cw(5'b0, 1'b0, 2'd1, 2'd0, 3'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0));
      chk("R2 loaded const one", pin_out, 1'b1);
      @(negedge clk);
      cfg_word = '0;
      repeat (3) @(negedge clk);
      #1;
      chk("R2 word ignored without strobe", pin_out, 1'b1);
   endtask

   task automatic t_sum();
      load(cw(5'b00101, 1'b1, 2'd0, 2'd0, 3'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0));
      pt = 5'b0; casc_in = 1'b0; #1;
      chk("R3 all low", casc_out, 1'b0);
      pt = 5'b00010; #1;
      chk("R3 masked term silent", casc_out, 1'b0);
      chk("R3 masked term pin", pin_out, 1'b0);
      pt = 5'b00100; #1;
      chk("R3 enabled term", casc_out, 1'b1);
      pt = 5'b0; casc_in = 1'b1; #1;
      chk("R3 cascade in", casc_out, 1'b1);
      load(cw(5'b00101, 1'b0, 2'd0, 2'd0, 3'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0));
      chk("R3 cascade disabled", casc_out, 1'b0);
      casc_in = 1'b0;
   endtask

   task automatic t_xor();
      load(cw(5'b00001, 1'b0, 2'd2, 2'd0, 3'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0));
      pt = 5'b10001; #1;
      chk("R4 sum1 op1", pin_out, 1'b0);
      pt = 5'b00001; #1;
      chk("R4 sum1 op0", pin_out, 1'b1);
      pt = 5'b10000; #1;
      chk("R4 sum0 op1", pin_out, 1'b1);
      load(cw(5'b00001, 1'b0, 2'd1, 2'd0, 3'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0));
      pt = 5'b00001; #1;
      chk("R4 const one inverts", pin_out, 1'b0);
      pt = 5'b0;
   endtask

   task automatic t_dsrc();
      set_state(1'b0);
      load(cw(5'b0, 1'b0, 2'd0, 2'd1, 3'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1));
      pt[3] = 1'b1; pulse(0); pt[3] = 1'b0;
      chk("R5 product term data", pin_out, 1'b1);
      load(cw(5'b0, 1'b0, 2'd0, 2'd2, 3'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1));
      pin_in = 1'b0; pulse(0);
      chk("R5 pin data 0", pin_out, 1'b0);
      pin_in = 1'b1; pulse(0);
      chk("R6 D load 1", pin_out, 1'b1);
      load(cw(5'b0, 1'b0, 2'd0, 2'd0, 3'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1));
      pulse(0);
      chk("R5 xor data", pin_out, 1'b0);
   endtask

   task automatic t_toggle();
      set_state(1'b0);
      load(cw(5'b0, 1'b0, 2'd1, 2'd0, 3'd1, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1));
      pulse(0);
      chk("R6 T toggle to 1", pin_out, 1'b1);
      pulse(0);
      chk("R6 T toggle to 0", pin_out, 1'b0);
      @(negedge clk); gclk[0] = 1'b1;
      repeat (3) @(negedge clk);
      gclk[0] = 1'b0; #1;
      chk("R9 held clock one event", pin_out, 1'b1);
   endtask

   task automatic t_jk();
      set_state(1'b0);
      load(cw(5'b0, 1'b0, 2'd0, 2'd1, 3'd2, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1));
      pt[3] = 1'b1; pt[2] = 1'b0; pulse(0);
      chk("R7 JK set", pin_out, 1'b1);
      pt[3] = 1'b0; pt[2] = 1'b0; pulse(0);
      chk("R7 JK hold", pin_out, 1'b1);
      pt[3] = 1'b0; pt[2] = 1'b1; pulse(0);
      chk("R7 JK clear", pin_out, 1'b0);
      pt[3] = 1'b1; pt[2] = 1'b1; pulse(0);
      chk("R7 JK toggle", pin_out, 1'b1);
      pt = 5'b0;
   endtask

   task automatic t_sr();
      set_state(1'b0);
      load(cw(5'b0, 1'b0, 2'd0, 2'd1, 3'd3, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1));
      pt[3] = 1'b1; pt[2] = 1'b0; pulse(0);
      chk("R7 SR set", pin_out, 1'b1);
      pt[3] = 1'b0; pt[2] = 1'b0; pulse(0);
      chk("R7 SR hold", pin_out, 1'b1);
      pt[3] = 1'b1; pt[2] = 1'b1; pulse(0);
      chk("R7 SR both clears", pin_out, 1'b0);
      pt[3] = 1'b1; pt[2] = 1'b0; pulse(0);
      pt[3] = 1'b0; pt[2] = 1'b1; pulse(0);
      chk("R7 SR reset", pin_out, 1'b0);
      pt = 5'b0;
   endtask

   task automatic t_latch();
      set_state(1'b0);
      load(cw(5'b0, 1'b0, 2'd0, 2'd2, 3'd4, 2'd1, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1));
      gclk[1] = 1'b1; pin_in = 1'b1; #1;
      chk("R8 transparent 1", pin_out, 1'b1);
      pin_in = 1'b0; #1;
      chk("R8 transparent 0", pin_out, 1'b0);
      @(negedge clk); pin_in = 1'b1;
      @(negedge clk); gclk[1] = 1'b0; pin_in = 1'b0; #1;
      chk("R8 holds when low", pin_out, 1'b1);
      @(negedge clk); #1;
      chk("R8 still held", pin_out, 1'b1);
   endtask

   task automatic t_clksrc();
      set_state(1'b0);
      load(cw(5'b0, 1'b0, 2'd0, 2'd2, 3'd0, 2'd2, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1));
      pin_in = 1'b1; pulse(0);
      chk("R9 unselected clock ignored", pin_out, 1'b0);
      pulse(2);
      chk("R9 gclk2 selected", pin_out, 1'b1);
      load(cw(5'b0, 1'b0, 2'd0, 2'd2, 3'd0, 2'd3, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1));
      pin_in = 1'b0; pulse(3);
      chk("R9 product clock", pin_out, 1'b0);
   endtask

   task automatic t_ce();
      set_state(1'b0);
      load(cw(5'b0, 1'b0, 2'd0, 2'd2, 3'd0, 2'd0, 1'b1, 2'd0, 1'b0, 1'b1, 1'b1));
      pin_in = 1'b1; pt[0] = 1'b0; pulse(0);
      chk("R10 enable low ignores", pin_out, 1'b0);
      pt[0] = 1'b1; pulse(0);
      chk("R10 enable high loads", pin_out, 1'b1);
      load(cw(5'b0, 1'b0, 2'd0, 2'd2, 3'd0, 2'd3, 1'b1, 2'd0, 1'b0, 1'b1, 1'b1));
      pt[0] = 1'b0; pin_in = 1'b0; pulse(3);
      chk("R10 product clock ungated", pin_out, 1'b0);
   endtask

   task automatic t_async();
      load(cw(5'b0, 1'b0, 2'd0, 2'd2, 3'd0, 2'd0, 1'b0, 2'd1, 1'b0, 1'b1, 1'b1));
      pin_in = 1'b1; pulse(0);
      gclr = 1'b1; #1;
      chk("R11 gclr immediate", pin_out, 1'b0);
      @(negedge clk); gclr = 1'b0; #1;
      chk("R11 gclr cleared state", pin_out, 1'b0);
      load(cw(5'b0, 1'b0, 2'd0, 2'd2, 3'd0, 2'd0, 1'b0, 2'd2, 1'b0, 1'b1, 1'b1));
      pulse(0);
      pt[1] = 1'b1; #1;
      chk("R11 pt clear", pin_out, 1'b0);
      @(negedge clk); pt[1] = 1'b0;
      load(cw(5'b0, 1'b0, 2'd0, 2'd2, 3'd0, 2'd0, 1'b0, 2'd3, 1'b0, 1'b1, 1'b1));
      pulse(0);
      gclr = 1'b1; #1;
      chk("R11 either source", pin_out, 1'b0);
      @(negedge clk); gclr = 1'b0;
      load(cw(5'b0, 1'b0, 2'd0, 2'd2, 3'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1));
      pulse(0);
      gclr = 1'b1; #1;
      chk("R11 clear off ignores gclr", pin_out, 1'b1);
      @(negedge clk); gclr = 1'b0;
      load(cw(5'b0, 1'b0, 2'd0, 2'd2, 3'd0, 2'd0, 1'b0, 2'd1, 1'b1, 1'b1, 1'b1));
      pin_in = 1'b0; pulse(0);
      pt[0] = 1'b1; #1;
      chk("R12 preset immediate", pin_out, 1'b1);
      @(negedge clk); gclr = 1'b1; #1;
      chk("R11 clear beats preset", pin_out, 1'b0);
      @(negedge clk); gclr = 1'b0; pt[0] = 1'b0; #1;
      chk("R11 state cleared under both", pin_out, 1'b0);
   endtask

   task automatic t_outfb();
      set_state(1'b1);
      load(cw(5'b0, 1'b0, 2'd0, 2'd0, 3'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0));
      chk("R13 pin registered", pin_out, 1'b1);
      chk("R13 fb combinational", fb_out, 1'b0);
      load(cw(5'b0, 1'b0, 2'd0, 2'd0, 3'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1));
      chk("R13 pin combinational", pin_out, 1'b0);
      chk("R13 fb registered", fb_out, 1'b1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      t_cfg_hold();
      t_sum();
      t_xor();
      t_dsrc();
      t_toggle();
      t_jk();
      t_sr();
      t_latch();
      t_clksrc();
      t_ce();
      t_async();
      t_outfb();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule